// File: doc/BRIEF.md
# SECDED Check-Byte Verifier

This block checks a 64-bit doubleword that comes out of storage together with an 8-bit check byte. It computes the check byte again from the data. Each check bit is the parity of the data bits picked out by one of eight fixed selection masks. It then compares the new byte with the stored one and sorts any mismatch into one of two classes. A mismatch on one bit is a single-bit error. A mismatch on more than one bit is a multi-bit error. Only the number of set bits in the syndrome decides the class.

The check runs in one registered stage. A caller presents data and stored check byte together with a strobe. One clock later the block returns the recomputed check byte, the syndrome and the two error flags, along with a result strobe. Between strobes the check byte and syndrome outputs keep their last values.

The block does not correct data and holds no storage array. A caller that needs correction decodes the syndrome downstream.

Top module: `ecc_chk_top`

## Requirements
- R1: Check bit i of `out_check` is the XOR of all bits of (data AND mask_i). mask_0 is 0x0738C808099264FF, and mask_i is mask_0 rotated left by 8*i bit positions. Bit 0 of each vector is its least significant bit.
- R2: `out_syndrome` equals `out_check` XOR the stored check byte presented with the same strobe.
- R3: A zero syndrome leaves both `out_single` and `out_multi` low.
- R4: A syndrome with exactly one set bit raises `out_single`.
- R5: A syndrome with two or more set bits raises `out_multi`.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The outputs in that cycle belong to that input.
- R7: `out_single` and `out_multi` are never high together, and both are low whenever `out_valid` is low.
- R8: After reset, `out_valid`, `out_single`, `out_multi`, `out_check` and `out_syndrome` are all zero.
- R9: While `in_valid` is low, `out_check` and `out_syndrome` keep their values, whatever `in_data` and `in_check` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_data | input | 64 | Data doubleword read from storage |
| in_check | input | 8 | Check byte stored with the data |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_check | output | 8 | Check byte recomputed from the data |
| out_syndrome | output | 8 | Recomputed XOR stored check byte |
| out_single | output | 1 | Single-bit error flag |
| out_multi | output | 1 | Multi-bit error flag |

## Verification
The bound assertions check the following on every cycle:
- the one-cycle strobe relation;
- that the flags exclude each other;
- that the flags follow the syndrome's population count;
- that the syndrome is consistent with the recomputed byte and the stored byte;
- that the outputs hold between strobes.

The assertions cannot check that the recomputed byte uses the right masks. Only the bench's scenarios show that, by comparing against an independent model. They drive random data with correct check bytes and with one or two flipped data or check bits, plus all-zero, all-one and single-bit-set patterns. The bench's scenarios also confirm that the reset values are zero.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam logic [DATA_W-1:0] BASE_MASK = 64'h0738_C808_0992_64FF;

    typedef struct packed {
        logic             vld;
        logic [CHK_W-1:0] chk;
        logic [CHK_W-1:0] syn;
        logic             sbe;
        logic             mbe;
    } ecc_res_t;

endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen #(
    parameter int                DATA_W    = 64,
    parameter int                CHK_W     = 8,
    parameter logic [DATA_W-1:0] BASE_MASK = 64'h0738_C808_0992_64FF
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    localparam int STEP = DATA_W / CHK_W;

    for (genvar g = 0; g < CHK_W; g++) begin : g_bit
        localparam int ROT = (g * STEP) % DATA_W;
        localparam logic [DATA_W-1:0] MASK =
            (ROT == 0) ? BASE_MASK
                       : ((BASE_MASK << ROT) | (BASE_MASK >> (DATA_W - ROT)));
        assign chk_o[g] = ^(data_i & MASK);
    end
endmodule

// File: rtl/ecc_chk_classify.sv
module ecc_chk_classify #(
    parameter int CHK_W = 8
) (
    input  logic [CHK_W-1:0] calc_i,
    input  logic [CHK_W-1:0] stored_i,
    output logic [CHK_W-1:0] syn_o,
    output logic             sbe_o,
    output logic             mbe_o
);
    localparam int CNT_W = $clog2(CHK_W + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        syn_o = calc_i ^ stored_i;
        ones  = '0;
        for (int i = 0; i < CHK_W; i++) begin
            ones = ones + CNT_W'(syn_o[i]);
        end
        sbe_o = (ones == CNT_W'(1));
        mbe_o = (ones > CNT_W'(1));
    end
endmodule

// File: rtl/ecc_chk_top.sv
module ecc_chk_top
    import ecc_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  in_check,
    output logic              out_valid,
    output logic [CHK_W-1:0]  out_check,
    output logic [CHK_W-1:0]  out_syndrome,
    output logic              out_single,
    output logic              out_multi
);
    logic [CHK_W-1:0] calc_w;
    logic [CHK_W-1:0] syn_w;
    logic             sbe_w;
    logic             mbe_w;
    ecc_res_t         res_d, res_q;

    ecc_chk_gen #(
        .DATA_W   (DATA_W),
        .CHK_W    (CHK_W),
        .BASE_MASK(BASE_MASK)
    ) u_gen (
        .data_i(in_data),
        .chk_o (calc_w)
    );

    ecc_chk_classify #(
        .CHK_W(CHK_W)
    ) u_cls (
        .calc_i  (calc_w),
        .stored_i(in_check),
        .syn_o   (syn_w),
        .sbe_o   (sbe_w),
        .mbe_o   (mbe_w)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        res_d.sbe = 1'b0;
        res_d.mbe = 1'b0;
        if (in_valid) begin
            res_d.chk = calc_w;
            res_d.syn = syn_w;
            res_d.sbe = sbe_w;
            res_d.mbe = mbe_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.vld;
    assign out_check    = res_q.chk;
    assign out_syndrome = res_q.syn;
    assign out_single   = res_q.sbe;
    assign out_multi    = res_q.mbe;
endmodule

// File: rtl/ecc_chk_top_chk.sv
module ecc_chk_top_chk #(
    parameter int CHK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [CHK_W-1:0] in_check,
    input logic             out_valid,
    input logic [CHK_W-1:0] out_check,
    input logic [CHK_W-1:0] out_syndrome,
    input logic             out_single,
    input logic             out_multi
);
    assert_strobe_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_strobe_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_syn_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_syndrome == (out_check ^ $past(in_check))));
    assert_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_syndrome == '0) |-> (!out_single && !out_multi));
    assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_syndrome) == 1) |-> out_single);
    assert_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_syndrome) > 1) |-> out_multi);
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_single && out_multi));
    assert_idle_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_single && !out_multi));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_check) && $stable(out_syndrome)));
endmodule

bind ecc_chk_top ecc_chk_top_chk #(.CHK_W(ecc_chk_pkg::CHK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_check    (in_check),
    .out_valid   (out_valid),
    .out_check   (out_check),
    .out_syndrome(out_syndrome),
    .out_single  (out_single),
    .out_multi   (out_multi)
);

// File: tb/ecc_chk_top_test.sv
`timescale 1ns/1ps
module ecc_chk_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        out_valid;
    logic [7:0]  out_check;
    logic [7:0]  out_syndrome;
    logic        out_single;
    logic        out_multi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecc_chk_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_check(in_check), .out_valid(out_valid), .out_check(out_check),
        .out_syndrome(out_syndrome), .out_single(out_single), .out_multi(out_multi)
    );

    function automatic logic [63:0] ref_mask(int idx);
        logic [63:0] m = 64'h0738C808099264FF;
        for (int k = 0; k < idx; k++) m = {m[55:0], m[63:56]};
        return m;
    endfunction

    function automatic logic [7:0] ref_check(logic [63:0] d);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) begin
            logic p = 1'b0;
            for (int b = 0; b < 64; b++) p ^= d[b] & ref_mask(i)[b];
            c[i] = p;
        end
        return c;
    endfunction

    task automatic expect_val(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Presents one word, then checks the registered result one cycle later.
    task automatic run_word(logic [63:0] d, logic [7:0] stored);
        logic [7:0] c = ref_check(d);
        logic [7:0] s = c ^ stored;
        int n = $countones(s);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_check = stored;
        @(negedge clk);
        in_valid = 1'b0;
        expect_val("R6", "out_valid", 64'(out_valid), 64'd1);
        expect_val("R1", "out_check", 64'(out_check), 64'(c));
        expect_val("R2", "out_syndrome", 64'(out_syndrome), 64'(s));
        expect_val(n == 0 ? "R3" : "R4", "out_single", 64'(out_single), 64'(n == 1));
        expect_val(n == 0 ? "R3" : "R5", "out_multi", 64'(out_multi), 64'(n > 1));
        expect_val("R7", "both_flags", 64'(out_single & out_multi), 64'd0);
    endtask

    initial begin
        logic [63:0] d;
        logic [7:0]  c0, s0;
        void'($urandom(32'd4242));
        #15;
        // R8: reset values
        expect_val("R8", "out_valid", 64'(out_valid), 64'd0);
        expect_val("R8", "out_check", 64'(out_check), 64'd0);
        expect_val("R8", "out_syndrome", 64'(out_syndrome), 64'd0);
        expect_val("R8", "flags", 64'({out_single, out_multi}), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed corner cases for R1 and R3
        run_word(64'd0, 8'd0);
        run_word(64'hFFFF_FFFF_FFFF_FFFF, ref_check(64'hFFFF_FFFF_FFFF_FFFF));
        for (int b = 0; b < 64; b += 9) run_word(64'd1 << b, ref_check(64'd1 << b));
        // R4: stored byte differs in one bit
        run_word(64'h0123_4567_89AB_CDEF, ref_check(64'h0123_4567_89AB_CDEF) ^ 8'h80);
        // R5: all check bits flipped
        run_word(64'h0, 8'hFF);

        for (int t = 0; t < 300; t++) begin
            d = {$urandom, $urandom};
            c0 = ref_check(d);
            case (t % 5)
                0: run_word(d, c0);
                1: run_word(d, c0 ^ (8'd1 << ($urandom % 8)));
                2: run_word(d ^ (64'd1 << ($urandom % 64)), c0);
                3: begin
                    int a = $urandom % 64;
                    int b = (a + 1 + ($urandom % 63)) % 64;
                    run_word(d ^ (64'd1 << a) ^ (64'd1 << b), c0);
                end
                default: begin
                    int a = $urandom % 8;
                    run_word(d, c0 ^ (8'd1 << a) ^ (8'd1 << ((a + 3) % 8)));
                end
            endcase
        end

        // R9 and R7: inputs move without strobe, outputs must hold
        run_word(64'hDEAD_BEEF_0000_1111, 8'h00);
        c0 = ref_check(64'hDEAD_BEEF_0000_1111);
        s0 = c0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            in_data = {$urandom, $urandom};
            in_check = 8'($urandom);
        end
        @(negedge clk);
        expect_val("R9", "held_check", 64'(out_check), 64'(c0));
        expect_val("R9", "held_syndrome", 64'(out_syndrome), 64'(s0));
        expect_val("R6", "out_valid_idle", 64'(out_valid), 64'd0);
        expect_val("R7", "idle_flags", 64'({out_single, out_multi}), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule